// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block decides which parts of a chip receive a clock and at what rate. It has three operating modes. In RUN everything software has enabled is clocked. In HALT the core domain stops: the CPU, the system bus, the bus control logic and the memory interfaces. In STANDBY the oscillator itself is switched off. Software enters HALT or STANDBY by writing a command register. The block returns to RUN on a wake event, and each mode accepts its own kinds of wake event. On the way out of STANDBY the block passes through a settle phase. During this phase the oscillator runs but every clock enable stays low until a programmed number of base cycles has passed.

While in RUN, software can stop or restart the clock of each peripheral group through a gating register. It can also set two divide ratios, called gears, one for the system clock strobe and one for the core clock strobe. A gear changes only at the divider's terminal count, so no shortened strobe period is produced. A strap pin, sampled while reset is asserted, can remove the DRAM group's clock. Once removed, that clock cannot come back until the next reset.

All clocks are modelled as enable strobes with respect to one base clock. The register port is a plain single-cycle write strobe that is always accepted, so it has no back-pressure. Status is presented on plain output pins.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the mode is RUN (0), the wake cause is reset (0), the core enable and the oscillator enable are high, every peripheral enable is high except bit DRAM_IDX (0) when the strap was high during reset, and both gears are /1, so both strobes are high on every RUN cycle.
- R2: A write to address 1 loads the gating register. Bit i set to 1 runs peripheral group i and bit i set to 0 stops it. Both stopping and restarting take effect in the cycle after the write.
- R3: The DRAM strap is sampled only while reset is asserted. When it was high, peripheral enable bit DRAM_IDX stays 0 whatever is written to the gating register and however the pin changes later.
- R4: A write to address 2 sets the system clock gear code from data bits [2:0] and the core clock gear code from data bits [6:4]. The two gears are independent. Code k gives one strobe every 2^k base cycles, and codes 6 and 7 act as /32.
- R5: A new gear code takes effect only after the divider's 5-bit phase counter reaches its terminal count, which happens once every 32 cycles. Every gap between two consecutive strobes therefore equals either the old period or the new period.
- R6: A write to address 0 requests a mode change through data bits [1:0]: value 1 requests HALT and value 2 requests STANDBY. Other values are ignored, and so are requests made outside RUN. The new mode is shown in the cycle after the write.
- R7: In HALT the core enable and both strobes are low, the oscillator enable stays high, and the peripheral enables keep following the gating register.
- R8: HALT is left in the cycle after any irq_i or ext_irq_i line is high. The mode becomes RUN and the cause becomes interrupt (1). port_wake_i has no effect in HALT.
- R9: In STANDBY the core enable, every peripheral enable, both strobes and the oscillator enable are all low.
- R10: STANDBY is left only by ext_irq_i, which gives cause 1 and wins a tie, or by port_wake_i, which gives cause 2. irq_i has no effect in STANDBY.
- R11: After a STANDBY wake the mode is SETTLE (3) for max(S,1) cycles. S is the settle count written to address 3 (data bits [15:0], reset value 16). During SETTLE the oscillator enable is high and every clock enable and strobe is low. The mode then returns to RUN.
- R12: mode_o reports 0 for RUN, 1 for HALT, 2 for STANDBY and 3 for SETTLE. wake_cause_o is updated on each wake and holds its value until the next wake or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | DATA_W | Register write data |
| irq_i | input | N_IRQ | Enabled internal interrupt requests |
| ext_irq_i | input | N_EXT | External interrupt requests |
| port_wake_i | input | N_PORT | Port-input wake lines |
| dram_strap_i | input | 1 | Strap that removes the DRAM clock, sampled during reset |
| core_clk_en_o | output | 1 | Clock enable for the CPU, the bus and the memory interfaces |
| periph_clk_en_o | output | N_PERIPH | Clock enable for each peripheral group |
| hclk_stb_o | output | 1 | Divided system clock strobe |
| cclk_stb_o | output | 1 | Divided core clock strobe |
| osc_en_o | output | 1 | Oscillator enable |
| mode_o | output | 2 | Current mode |
| wake_cause_o | output | 2 | Cause of the last wake |

## Verification
The assertions check the output levels of each mode on every cycle. HALT must keep the core domain dark, STANDBY must keep everything dark with the oscillator off, and SETTLE must keep every enable low. They also check that the DRAM group stays off after a strapped reset, and that HALT and STANDBY persist for as long as none of their own wake sources is active. Only the bench scenarios can show that the exact cycle counts are right: the settle length, the strobe counts for each gear code, and the strobe gaps around a gear change. The same holds for the wake cause values and for write commands that must be ignored.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_HALT   = 2'd1,
    MODE_STBY   = 2'd2,
    MODE_SETTLE = 2'd3
  } pcc_mode_e;

  typedef enum logic [1:0] {
    CAUSE_RESET = 2'd0,
    CAUSE_IRQ   = 2'd1,
    CAUSE_PORT  = 2'd2
  } pcc_cause_e;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_GATE   = 2'd1;
  localparam logic [1:0] ADDR_GEAR   = 2'd2;
  localparam logic [1:0] ADDR_SETTLE = 2'd3;

  localparam logic [1:0] CMD_HALT = 2'd1;
  localparam logic [1:0] CMD_STBY = 2'd2;

  localparam int GEAR_W  = 3;
  localparam int N_GEARS = 2;

endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
  import pcc_pkg::*;
#(
  parameter int N_PERIPH   = 8,
  parameter int DRAM_IDX   = 0,
  parameter int DATA_W     = 16,
  parameter int SETTLE_W   = 16,
  parameter int SETTLE_RST = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                dram_strap_i,
  input  logic                in_run_i,
  output logic [N_PERIPH-1:0] gate_o,
  output logic [GEAR_W-1:0]   gear_o [N_GEARS],
  output logic [SETTLE_W-1:0] settle_o,
  output logic                halt_req_o,
  output logic                stby_req_o
);

  localparam logic [N_PERIPH-1:0] DRAM_BIT = N_PERIPH'(1) << DRAM_IDX;

  logic                dram_off_q;
  logic [N_PERIPH-1:0] gate_q;
  logic [GEAR_W-1:0]   gear_q [N_GEARS];
  logic [SETTLE_W-1:0] settle_q;
  logic [N_PERIPH-1:0] dram_mask;

  assign dram_mask = dram_off_q ? DRAM_BIT : '0;

  // strap is captured only while reset is asserted
  always_ff @(posedge clk_i) begin
    if (rst_i) dram_off_q <= dram_strap_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gate_q   <= dram_strap_i ? ~DRAM_BIT : '1;
      settle_q <= SETTLE_W'(SETTLE_RST);
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_GATE)   gate_q   <= wr_data_i[N_PERIPH-1:0] & ~dram_mask;
      if (wr_addr_i == ADDR_SETTLE) settle_q <= wr_data_i[SETTLE_W-1:0];
    end
  end

  for (genvar g = 0; g < N_GEARS; g++) begin : g_gear
    always_ff @(posedge clk_i) begin
      if (rst_i) gear_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_GEAR)
        gear_q[g] <= wr_data_i[4*g +: GEAR_W];
    end
    assign gear_o[g] = gear_q[g];
  end

  assign gate_o   = gate_q & ~dram_mask;
  assign settle_o = settle_q;

  always_comb begin
    halt_req_o = 1'b0;
    stby_req_o = 1'b0;
    if (wr_en_i && in_run_i && wr_addr_i == ADDR_MODE) begin
      halt_req_o = (wr_data_i[1:0] == CMD_HALT);
      stby_req_o = (wr_data_i[1:0] == CMD_STBY);
    end
  end

endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int N_EXT    = 2,
  parameter int N_PORT   = 4,
  parameter int SETTLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                halt_req_i,
  input  logic                stby_req_i,
  input  logic [N_IRQ-1:0]    irq_i,
  input  logic [N_EXT-1:0]    ext_irq_i,
  input  logic [N_PORT-1:0]   port_wake_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output pcc_mode_e           mode_o,
  output pcc_cause_e          cause_o
);

  pcc_mode_e           mode_q, mode_d;
  pcc_cause_e          cause_q, cause_d;
  logic [SETTLE_W-1:0] cnt_q;
  logic                load_cnt;
  logic                any_irq, any_ext, any_port;

  assign any_irq  = |irq_i;
  assign any_ext  = |ext_irq_i;
  assign any_port = |port_wake_i;

  always_comb begin
    mode_d   = mode_q;
    cause_d  = cause_q;
    load_cnt = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (stby_req_i)      mode_d = MODE_STBY;
        else if (halt_req_i) mode_d = MODE_HALT;
      end
      MODE_HALT: begin
        if (any_irq || any_ext) begin
          mode_d  = MODE_RUN;
          cause_d = CAUSE_IRQ;
        end
      end
      MODE_STBY: begin
        if (any_ext) begin
          mode_d   = MODE_SETTLE;
          cause_d  = CAUSE_IRQ;
          load_cnt = 1'b1;
        end else if (any_port) begin
          mode_d   = MODE_SETTLE;
          cause_d  = CAUSE_PORT;
          load_cnt = 1'b1;
        end
      end
      MODE_SETTLE: begin
        if (cnt_q <= SETTLE_W'(1)) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q  <= MODE_RUN;
      cause_q <= CAUSE_RESET;
      cnt_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      cause_q <= cause_d;
      if (load_cnt)
        cnt_q <= settle_i;
      else if (mode_q == MODE_SETTLE && cnt_q > SETTLE_W'(1))
        cnt_q <= cnt_q - SETTLE_W'(1);
    end
  end

  assign mode_o  = mode_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/pcc_gear_div.sv
module pcc_gear_div
  import pcc_pkg::*;
#(
  parameter int MAX_SHIFT = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [GEAR_W-1:0] code_i,
  output logic              stb_o
);

  localparam int CNT_W = MAX_SHIFT;
  localparam int SH_W  = $clog2(MAX_SHIFT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SH_W-1:0]  shift_q;
  logic [SH_W-1:0]  shift_new;
  logic [CNT_W-1:0] mask;
  logic             terminal;

  assign shift_new = (int'(code_i) > MAX_SHIFT) ? SH_W'(MAX_SHIFT) : SH_W'(code_i);
  assign terminal  = &cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      // ratio switch only where every phase ends together
      if (terminal) shift_q <= shift_new;
    end
  end

  assign mask  = (CNT_W'(1) << shift_q) - CNT_W'(1);
  assign stb_o = ((cnt_q & mask) == mask);

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int N_PERIPH   = 8,
  parameter int DRAM_IDX   = 0,
  parameter int N_IRQ      = 4,
  parameter int N_EXT      = 2,
  parameter int N_PORT     = 4,
  parameter int DATA_W     = 16,
  parameter int SETTLE_W   = 16,
  parameter int SETTLE_RST = 16,
  parameter int MAX_SHIFT  = 5
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [N_IRQ-1:0]    irq_i,
  input  logic [N_EXT-1:0]    ext_irq_i,
  input  logic [N_PORT-1:0]   port_wake_i,
  input  logic                dram_strap_i,
  output logic                core_clk_en_o,
  output logic [N_PERIPH-1:0] periph_clk_en_o,
  output logic                hclk_stb_o,
  output logic                cclk_stb_o,
  output logic                osc_en_o,
  output logic [1:0]          mode_o,
  output logic [1:0]          wake_cause_o
);

  logic [N_PERIPH-1:0] gate;
  logic [GEAR_W-1:0]   gear [N_GEARS];
  logic [N_GEARS-1:0]  div_stb;
  logic [SETTLE_W-1:0] settle;
  logic                halt_req, stby_req;
  pcc_mode_e           mode;
  pcc_cause_e          cause;
  logic                in_run, in_halt, in_stby;

  assign in_run  = (mode == MODE_RUN);
  assign in_halt = (mode == MODE_HALT);
  assign in_stby = (mode == MODE_STBY);

  pcc_regs #(
    .N_PERIPH  (N_PERIPH),
    .DRAM_IDX  (DRAM_IDX),
    .DATA_W    (DATA_W),
    .SETTLE_W  (SETTLE_W),
    .SETTLE_RST(SETTLE_RST)
  ) regs_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .dram_strap_i(dram_strap_i),
    .in_run_i    (in_run),
    .gate_o      (gate),
    .gear_o      (gear),
    .settle_o    (settle),
    .halt_req_o  (halt_req),
    .stby_req_o  (stby_req)
  );

  pcc_mode_fsm #(
    .N_IRQ   (N_IRQ),
    .N_EXT   (N_EXT),
    .N_PORT  (N_PORT),
    .SETTLE_W(SETTLE_W)
  ) fsm_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .halt_req_i (halt_req),
    .stby_req_i (stby_req),
    .irq_i      (irq_i),
    .ext_irq_i  (ext_irq_i),
    .port_wake_i(port_wake_i),
    .settle_i   (settle),
    .mode_o     (mode),
    .cause_o    (cause)
  );

  for (genvar g = 0; g < N_GEARS; g++) begin : g_div
    pcc_gear_div #(
      .MAX_SHIFT(MAX_SHIFT)
    ) div_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .code_i(gear[g]),
      .stb_o (div_stb[g])
    );
  end

  assign core_clk_en_o   = in_run;
  assign periph_clk_en_o = (in_run || in_halt) ? gate : '0;
  assign hclk_stb_o      = in_run & div_stb[0];
  assign cclk_stb_o      = in_run & div_stb[1];
  assign osc_en_o        = ~in_stby;
  assign mode_o          = mode;
  assign wake_cause_o    = cause;

endmodule

// File: rtl/pcc_chk.sv
module pcc_chk
  import pcc_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int DRAM_IDX = 0,
  parameter int N_IRQ    = 4,
  parameter int N_EXT    = 2,
  parameter int N_PORT   = 4
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                dram_strap_i,
  input logic [N_IRQ-1:0]    irq_i,
  input logic [N_EXT-1:0]    ext_irq_i,
  input logic [N_PORT-1:0]   port_wake_i,
  input logic                core_clk_en_o,
  input logic [N_PERIPH-1:0] periph_clk_en_o,
  input logic                hclk_stb_o,
  input logic                cclk_stb_o,
  input logic                osc_en_o,
  input logic [1:0]          mode_o
);

  logic strap_seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) strap_seen_q <= dram_strap_i;
  end

  // R3
  dram_strap_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    strap_seen_q |-> !periph_clk_en_o[DRAM_IDX]);

  // R7
  halt_core_dark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == MODE_HALT) |-> (!core_clk_en_o && osc_en_o && !hclk_stb_o && !cclk_stb_o));

  // R8
  halt_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == MODE_HALT && !(|irq_i) && !(|ext_irq_i)) |=> (mode_o == MODE_HALT));

  // R9
  stby_all_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == MODE_STBY) |-> (!osc_en_o && !core_clk_en_o && periph_clk_en_o == '0
                               && !hclk_stb_o && !cclk_stb_o));

  // R10
  stby_holds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == MODE_STBY && !(|ext_irq_i) && !(|port_wake_i)) |=> (mode_o == MODE_STBY));

  // R11
  settle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == MODE_SETTLE) |-> (osc_en_o && !core_clk_en_o && periph_clk_en_o == '0
                                 && !hclk_stb_o && !cclk_stb_o));

  // R12
  run_core_live_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_o == MODE_RUN) |-> (core_clk_en_o && osc_en_o));

endmodule

bind pwr_clk_ctrl pcc_chk #(
  .N_PERIPH(N_PERIPH),
  .DRAM_IDX(DRAM_IDX),
  .N_IRQ   (N_IRQ),
  .N_EXT   (N_EXT),
  .N_PORT  (N_PORT)
) chk_i (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .dram_strap_i   (dram_strap_i),
  .irq_i          (irq_i),
  .ext_irq_i      (ext_irq_i),
  .port_wake_i    (port_wake_i),
  .core_clk_en_o  (core_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o),
  .hclk_stb_o     (hclk_stb_o),
  .cclk_stb_o     (cclk_stb_o),
  .osc_en_o       (osc_en_o),
  .mode_o         (mode_o)
);

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;

  localparam logic [15:0] M_MODE  = 16'hC000;
  localparam logic [15:0] M_CAUSE = 16'h3000;
  localparam logic [15:0] M_OSC   = 16'h0800;
  localparam logic [15:0] M_CORE  = 16'h0400;
  localparam logic [15:0] M_STB   = 16'h0300;
  localparam logic [15:0] M_PER   = 16'h00FF;
  localparam logic [15:0] M_ALL   = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  irq = '0;
  logic [1:0]  ext = '0;
  logic [3:0]  port = '0;
  logic        strap = 1'b0;
  logic        core_en, hstb, cstb, osc;
  logic [7:0]  per_en;
  logic [1:0]  mode, cause;

  always #2 clk = ~clk;

  pwr_clk_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_i(irq), .ext_irq_i(ext), .port_wake_i(port), .dram_strap_i(strap),
    .core_clk_en_o(core_en), .periph_clk_en_o(per_en), .hclk_stb_o(hstb), .cclk_stb_o(cstb),
    .osc_en_o(osc), .mode_o(mode), .wake_cause_o(cause)
  );

  typedef struct {
    int          cyc;
    int          req;
    logic [15:0] exp;
    logic [15:0] mask;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  function automatic logic [15:0] mk(logic [1:0] m, logic [1:0] c, logic o, logic k,
                                     logic h, logic s, logic [7:0] p);
    return {m, c, o, k, h, s, p};
  endfunction

  task automatic cmp(int req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_at(int k, int req, logic [15:0] e, logic [15:0] m);
    item_t it;
    it.cyc = cyc + k; it.req = req; it.exp = e; it.mask = m;
    sb_q.push_back(it);
  endtask

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        item_t it;
        logic [15:0] o;
        it = sb_q.pop_front();
        o = {mode, cause, osc, core_en, hstb, cstb, per_en};
        cmp(it.req, int'(o & it.mask), int'(it.exp & it.mask), "scoreboard item");
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(logic s);
    rst = 1'b1; strap = s;
    tick(4);
    rst = 1'b0;
  endtask

  task automatic count_stb(int n, output int hc, output int cc);
    hc = 0; cc = 0;
    repeat (n) begin
      @(negedge clk);
      if (hstb) hc++;
      if (cstb) cc++;
    end
  endtask

  // R5: measure every system-strobe gap across a gear change
  task automatic gap_test(int old_code, int new_code);
    int last, bad, gap, lastgap, op, np;
    op = 1 << old_code; np = 1 << new_code;
    wr(2'd2, 16'(old_code));
    tick(40);
    wr(2'd2, 16'(new_code));
    last = -1; bad = 0; lastgap = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hstb) begin
        if (last >= 0) begin
          gap = i - last;
          lastgap = gap;
          if (gap != op && gap != np) bad++;
        end
        last = i;
      end
    end
    cmp(5, bad, 0, "strobe gaps outside old/new period");
    cmp(5, lastgap, np, "final strobe period");
  endtask

  initial begin
    int hc, cc;
    do_reset(1'b0);
    // R1 reset state (strap low)
    expect_at(0, 1, mk(2'd0, 2'd0, 1, 1, 1, 1, 8'hFF), M_ALL);
    tick(2);

    // R4 default and programmed gears
    count_stb(64, hc, cc);
    cmp(4, hc, 64, "hclk strobes at /1");
    cmp(4, cc, 64, "cclk strobes at /1");
    wr(2'd2, 16'h0042);
    tick(40);
    count_stb(64, hc, cc);
    cmp(4, hc, 16, "hclk strobes at /4");
    cmp(4, cc, 4, "cclk strobes at /16");
    wr(2'd2, 16'h0076);
    tick(40);
    count_stb(64, hc, cc);
    cmp(4, hc, 2, "hclk strobes code 6");
    cmp(4, cc, 2, "cclk strobes code 7");

    // R5 gear change without runt periods
    gap_test(1, 4);
    gap_test(3, 1);
    wr(2'd2, 16'h0000);
    tick(40);

    // R2 gating stop and restart
    expect_at(1, 2, mk(0, 0, 0, 0, 0, 0, 8'h5A), M_PER);
    wr(2'd1, 16'h005A);
    expect_at(1, 2, mk(0, 0, 0, 0, 0, 0, 8'hFF), M_PER);
    wr(2'd1, 16'h00FF);

    // R6 ignored mode codes
    expect_at(1, 6, mk(2'd0, 0, 0, 0, 0, 0, 0), M_MODE);
    wr(2'd0, 16'h0003);
    expect_at(1, 6, mk(2'd0, 0, 0, 0, 0, 0, 0), M_MODE);
    wr(2'd0, 16'h0000);

    // R6 R7 enter HALT with a partial gate
    expect_at(1, 2, mk(0, 0, 0, 0, 0, 0, 8'h3C), M_PER);
    wr(2'd1, 16'h003C);
    expect_at(1, 7, mk(2'd1, 2'd0, 1, 0, 0, 0, 8'h3C), M_ALL);
    wr(2'd0, 16'h0001);
    // R8 port wake has no effect in HALT
    expect_at(1, 8, mk(2'd1, 2'd0, 1, 0, 0, 0, 8'h3C), M_ALL);
    port = 4'h2; tick(1); port = '0;
    expect_at(1, 8, mk(2'd1, 0, 0, 0, 0, 0, 0), M_MODE);
    tick(1);
    // R8 interrupt wakes HALT
    expect_at(1, 8, mk(2'd0, 2'd1, 1, 1, 0, 0, 8'h3C), M_MODE | M_CAUSE | M_OSC | M_CORE | M_PER);
    irq = 4'h4; tick(1); irq = '0;
    tick(1);
    wr(2'd1, 16'h00FF);

    // R9 R11 STANDBY, port wake, settle of 5
    wr(2'd3, 16'd5);
    expect_at(1, 9, mk(2'd2, 2'd1, 0, 0, 0, 0, 8'h00), M_ALL);
    wr(2'd0, 16'h0002);
    // R10 internal irq ignored in STANDBY
    expect_at(1, 10, mk(2'd2, 2'd1, 0, 0, 0, 0, 8'h00), M_ALL);
    irq = 4'h1; tick(1); irq = '0;
    tick(2);
    for (int k = 1; k <= 5; k++)
      expect_at(k, 11, mk(2'd3, 0, 1, 0, 0, 0, 8'h00), M_MODE | M_OSC | M_CORE | M_STB | M_PER);
    expect_at(6, 12, mk(2'd0, 2'd2, 1, 1, 0, 0, 8'hFF), M_MODE | M_CAUSE | M_OSC | M_CORE | M_PER);
    port = 4'h8; tick(1); port = '0;
    tick(8);
    // R12 cause holds in RUN
    expect_at(1, 12, mk(2'd0, 2'd2, 0, 0, 0, 0, 0), M_MODE | M_CAUSE);
    tick(2);

    // R10 R11 external interrupt wake, settle count 0 behaves as 1
    wr(2'd3, 16'd0);
    expect_at(1, 9, mk(2'd2, 2'd2, 0, 0, 0, 0, 8'h00), M_ALL);
    wr(2'd0, 16'h0002);
    expect_at(1, 11, mk(2'd3, 2'd1, 1, 0, 0, 0, 8'h00), M_ALL);
    expect_at(2, 10, mk(2'd0, 2'd1, 1, 1, 0, 0, 8'hFF), M_MODE | M_CAUSE | M_OSC | M_CORE | M_PER);
    ext = 2'b01; port = 4'h1; tick(1); ext = '0; port = '0;
    tick(3);

    // R1 R3 strapped reset, later pin change and writes ignored
    do_reset(1'b1);
    expect_at(0, 1, mk(2'd0, 2'd0, 1, 1, 1, 1, 8'hFE), M_ALL);
    tick(2);
    strap = 1'b0;
    expect_at(1, 3, mk(0, 0, 0, 0, 0, 0, 8'hFE), M_PER);
    wr(2'd1, 16'h00FF);
    expect_at(1, 3, mk(0, 0, 0, 0, 0, 0, 8'h80), M_PER);
    wr(2'd1, 16'h0081);
    tick(3);

    while (sb_q.size() > 0) tick(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule